// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access may proceed to a page that has already been translated. The access is a load, a store or an instruction fetch. Three independent sources each grant a subset of read, write and execute permission, and the block ANDs them together. The first source is the page-protection code of the page-table entry, decoded under a segment key that depends on privilege. The second is the no-execute/guarded marking of the entry. The third is a pair of per-key authority masks, selected by the entry's storage key.

The block returns the combined permission vector and a grant flag. It also returns the fault cause bits that an instruction-fetch interrupt or a data interrupt would record, one bit for each source that took the needed permission away. Raising the interrupt and saving state are done by the surrounding logic. With `REG_OUT=1` (the default), every output is registered once. With `REG_OUT=0` the outputs follow the inputs combinationally.

Top module: `page_perm_eval`

## Requirements
- R1: The protection key is `seg_key_user` when `user_mode` is 1, and `seg_key_sup` when `user_mode` is 0.
- R2: The protection code is `{pp_hi, pp_lo}` (pp_hi is the most significant bit). Under key 0, codes 0, 1 and 2 grant read/write/execute, codes 3 and 6 grant read/execute, and codes 4, 5 and 7 grant nothing.
- R3: Under key 1, codes 2 grant read/write/execute, codes 1 and 3 grant read/execute, and codes 0, 4, 5, 6 and 7 grant nothing.
- R4: If `pte_noexec` or `pte_guard` is set, execute permission is removed. Read and write permission are unchanged.
- R5: For storage key k, the authority pair is `amask[2*(31-k)+1 : 2*(31-k)]`. Bit 2*(31-k)+1 removes write permission and bit 2*(31-k) removes read permission.
- R6: When `imask_en` is 1, bit 2*(31-k) of `imask` removes execute permission only. When `imask_en` is 0, `imask` has no effect.
- R7: When `key_mask_en` is 0, neither `amask` nor `imask` has any effect.
- R8: `perm` is {read, write, execute} = bits [2], [1], [0], and is the AND of the three sources. The `acc_kind` encodings are 0 = load (needs read), 1 = store (needs write), 2 = fetch (needs execute), and 3 = treated as load. `grant` is 1 exactly when the needed bit is present in `perm`.
- R9: On a denied fetch, `if_nxg` is set if the no-execute/guard source removed execute. Otherwise `if_prot` is set if the protection code removed execute. Independently of both, `if_key` is set if the instruction mask removed execute.
- R10: On a denied load or store, `df_prot` is set if the protection code removed the needed bit, and `df_key` is set if the authority mask removed it. `df_store` is set on every denied store.
- R11: All cause bits are 0 when access is granted, the instruction causes are 0 for data accesses, and the data causes are 0 for fetches. With `REG_OUT=1`, outputs reflect the inputs sampled at the previous rising clock edge, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| user_mode | input | 1 | Problem (user) state |
| seg_key_user | input | 1 | Segment key bit used in user state |
| seg_key_sup | input | 1 | Segment key bit used in supervisor state |
| pp_hi | input | 1 | High bit of the protection code |
| pp_lo | input | 2 | Low two bits of the protection code |
| pte_noexec | input | 1 | Entry no-execute marking |
| pte_guard | input | 1 | Entry guarded marking |
| pte_key | input | KEY_W | Storage key of the entry |
| amask | input | 2*2**KEY_W | Data authority mask |
| imask | input | 2*2**KEY_W | Instruction authority mask |
| key_mask_en | input | 1 | Enables key-mask protection |
| imask_en | input | 1 | Enables the instruction mask |
| perm | output | 3 | Combined permission {R,W,X} |
| grant | output | 1 | Access allowed |
| if_nxg | output | 1 | Fetch cause: no-execute/guard |
| if_prot | output | 1 | Fetch cause: protection code |
| if_key | output | 1 | Fetch cause: instruction mask |
| df_prot | output | 1 | Data cause: protection code |
| df_key | output | 1 | Data cause: authority mask |
| df_store | output | 1 | Data cause: access was a store |

## Verification
The hardest situations to reach are the fetch-cause orderings, where two sources remove execute at the same time. The stimulus reaches them directly. It combines a no-execute marking with a forbidding protection code to show that only the no-execute cause is reported. It then pairs a forbidding code with a set instruction-mask bit to show that both the protection cause and the key cause are reported. Random masks seldom place a set bit at the pair selected by the storage key. For that reason, directed vectors set single bits at 2*(31-k) and 2*(31-k)+1 for chosen keys, and also at the neighbouring positions that must be ignored. The bench model recomputes every vector from the requirement tables, and a long random run follows.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  // permission vector bit positions
  localparam int PB_R = 2;
  localparam int PB_W = 1;
  localparam int PB_X = 0;

  typedef logic [2:0] rwx_t;

  typedef struct packed {
    logic i_nxg;
    logic i_prot;
    logic i_key;
    logic d_prot;
    logic d_key;
    logic d_store;
  } cause_t;

  // protection code decode under the selected key
  function automatic rwx_t pp_to_rwx(input logic key, input logic [2:0] code);
    rwx_t r;
    r = 3'b000;
    if (!key) begin
      unique case (code)
        3'd0, 3'd1, 3'd2: r = 3'b111;
        3'd3, 3'd6:       r = 3'b101;
        default:          r = 3'b000;
      endcase
    end else begin
      unique case (code)
        3'd2:       r = 3'b111;
        3'd1, 3'd3: r = 3'b101;
        default:    r = 3'b000;
      endcase
    end
    return r;
  endfunction

  // permission bit an access needs
  function automatic rwx_t need_of(input acc_e a);
    rwx_t n;
    unique case (a)
      ACC_STORE: n = 3'b010;
      ACC_FETCH: n = 3'b001;
      default:   n = 3'b100;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/perm_pp_stage.sv
module perm_pp_stage
  import page_perm_pkg::*;
(
  input  logic       user_mode,
  input  logic       key_user,
  input  logic       key_sup,
  input  logic [2:0] code,
  output logic       key_sel,
  output rwx_t       pp_rwx
);
  always_comb begin
    key_sel = user_mode ? key_user : key_sup;
    pp_rwx  = pp_to_rwx(key_sel, code);
  end
endmodule

// File: rtl/perm_mask_stage.sv
module perm_mask_stage
  import page_perm_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic [KEY_W-1:0]          key,
  input  logic [2*(1<<KEY_W)-1:0]   amask,
  input  logic [2*(1<<KEY_W)-1:0]   imask,
  input  logic                      mask_en,
  input  logic                      imask_en,
  output logic [1:0]                a_pair,
  output logic                      i_bit,
  output rwx_t                      mask_rwx
);
  localparam int NKEYS = 1 << KEY_W;
  localparam int IDX_W = KEY_W + 2;

  logic [IDX_W-1:0] base;

  always_comb begin
    // pair for key k sits at shift 2*(NKEYS-1-k)
    base     = IDX_W'(2 * (NKEYS - 1 - int'(key)));
    a_pair   = amask[base +: 2];
    i_bit    = imask[base];
    mask_rwx = 3'b111;
    if (mask_en) begin
      if (a_pair[1]) mask_rwx[PB_W] = 1'b0;
      if (a_pair[0]) mask_rwx[PB_R] = 1'b0;
      if (imask_en && i_bit) mask_rwx[PB_X] = 1'b0;
    end
  end
endmodule

// File: rtl/perm_cause_gen.sv
module perm_cause_gen
  import page_perm_pkg::*;
(
  input  acc_e   acc,
  input  rwx_t   nx_rwx,
  input  rwx_t   pp_rwx,
  input  rwx_t   mk_rwx,
  output rwx_t   perm,
  output logic   grant,
  output cause_t cause
);
  rwx_t need;
  logic fetch, deny;

  always_comb begin
    need  = need_of(acc);
    perm  = nx_rwx & pp_rwx & mk_rwx;
    grant = |(perm & need);
    deny  = ~grant;
    fetch = (acc == ACC_FETCH);
    cause.i_nxg   = deny & fetch & ~nx_rwx[PB_X];
    cause.i_prot  = deny & fetch & nx_rwx[PB_X] & ~pp_rwx[PB_X];
    cause.i_key   = deny & fetch & ~mk_rwx[PB_X];
    cause.d_prot  = deny & ~fetch & (|(need & ~pp_rwx));
    cause.d_key   = deny & ~fetch & (|(need & ~mk_rwx));
    cause.d_store = deny & (acc == ACC_STORE);
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import page_perm_pkg::*;
#(
  parameter int KEY_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              acc_kind,
  input  logic                    user_mode,
  input  logic                    seg_key_user,
  input  logic                    seg_key_sup,
  input  logic                    pp_hi,
  input  logic [1:0]              pp_lo,
  input  logic                    pte_noexec,
  input  logic                    pte_guard,
  input  logic [KEY_W-1:0]        pte_key,
  input  logic [2*(1<<KEY_W)-1:0] amask,
  input  logic [2*(1<<KEY_W)-1:0] imask,
  input  logic                    key_mask_en,
  input  logic                    imask_en,
  output logic [2:0]              perm,
  output logic                    grant,
  output logic                    if_nxg,
  output logic                    if_prot,
  output logic                    if_key,
  output logic                    df_prot,
  output logic                    df_key,
  output logic                    df_store
);
  acc_e       acc;
  logic       key_sel;
  rwx_t       pp_rwx, nx_rwx, mk_rwx, perm_c;
  logic [1:0] a_pair;
  logic       i_bit;
  logic       grant_c;
  cause_t     cause_c, cause_q;
  rwx_t       perm_q;
  logic       grant_q;

  assign acc    = acc_e'(acc_kind);
  assign nx_rwx = (pte_noexec | pte_guard) ? 3'b110 : 3'b111;

  perm_pp_stage u_pp (
    .user_mode (user_mode),
    .key_user  (seg_key_user),
    .key_sup   (seg_key_sup),
    .code      ({pp_hi, pp_lo}),
    .key_sel   (key_sel),
    .pp_rwx    (pp_rwx)
  );

  perm_mask_stage #(.KEY_W(KEY_W)) u_mask (
    .key      (pte_key),
    .amask    (amask),
    .imask    (imask),
    .mask_en  (key_mask_en),
    .imask_en (imask_en),
    .a_pair   (a_pair),
    .i_bit    (i_bit),
    .mask_rwx (mk_rwx)
  );

  perm_cause_gen u_cause (
    .acc    (acc),
    .nx_rwx (nx_rwx),
    .pp_rwx (pp_rwx),
    .mk_rwx (mk_rwx),
    .perm   (perm_c),
    .grant  (grant_c),
    .cause  (cause_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          perm_q  <= '0;
          grant_q <= 1'b0;
          cause_q <= '0;
        end else begin
          perm_q  <= perm_c;
          grant_q <= grant_c;
          cause_q <= cause_c;
        end
      end
    end else begin : g_comb
      assign perm_q  = perm_c;
      assign grant_q = grant_c;
      assign cause_q = cause_c;
    end
  endgenerate

  assign perm     = perm_q;
  assign grant    = grant_q;
  assign if_nxg   = cause_q.i_nxg;
  assign if_prot  = cause_q.i_prot;
  assign if_key   = cause_q.i_key;
  assign df_prot  = cause_q.d_prot;
  assign df_key   = cause_q.d_key;
  assign df_store = cause_q.d_store;

  // R4
  nxg_drops_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_noexec || pte_guard) |-> (!perm_c[PB_X] && perm_c[PB_R] == (pp_rwx[PB_R] & mk_rwx[PB_R])));

  // R7
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_mask_en |-> (mk_rwx == 3'b111));

  // R5
  amask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mask_en && a_pair[1]) |-> !perm_c[PB_W]);

  // R6
  imask_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mask_en && imask_en && i_bit) |-> (!perm_c[PB_X] && mk_rwx[PB_R] == !a_pair[0]));

  // R9
  fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_FETCH && !grant_c) |-> (cause_c.i_nxg || cause_c.i_prot || cause_c.i_key));

  // R9
  nxg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_c.i_nxg |-> !cause_c.i_prot);

  // R10
  store_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_STORE && !grant_c) |-> cause_c.d_store);

  // R11
  quiet_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_c |-> (cause_c == '0));

  // R11
  side_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((cause_c.i_nxg || cause_c.i_prot || cause_c.i_key) &&
      (cause_c.d_prot || cause_c.d_key || cause_c.d_store)));
endmodule

// File: tb/sim_page_perm_eval.sv
`timescale 1ns/1ps
module sim_page_perm_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic        user_mode = 1'b0, seg_key_user = 1'b0, seg_key_sup = 1'b0;
  logic        pp_hi = 1'b0;
  logic [1:0]  pp_lo = 2'd0;
  logic        pte_noexec = 1'b0, pte_guard = 1'b0;
  logic [4:0]  pte_key = 5'd0;
  logic [63:0] amask = 64'd0, imask = 64'd0;
  logic        key_mask_en = 1'b1, imask_en = 1'b1;
  logic [2:0]  perm;
  logic        grant, if_nxg, if_prot, if_key, df_prot, df_key, df_store;

  page_perm_eval u0 (.*);

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // staged next vector
  logic [1:0]  n_acc;
  logic        n_user, n_ku, n_ks, n_nx, n_g, n_men, n_ien;
  logic [2:0]  n_code;
  logic [4:0]  n_key;
  logic [63:0] n_am, n_im;

  // pending expectation
  bit          pend = 0;
  string       p_tag;
  logic [2:0]  e_perm;
  logic        e_grant;
  logic [5:0]  e_cause;

  task automatic chk(string tag, string what, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic defaults();
    n_acc = 2'd0; n_user = 0; n_ku = 0; n_ks = 0; n_nx = 0; n_g = 0;
    n_men = 1; n_ien = 1; n_code = 3'd0; n_key = 5'd0; n_am = 64'd0; n_im = 64'd0;
  endtask

  // behavioural model from the requirement tables
  task automatic model();
    int k, c, a, b, m, tot, need, sh;
    bit deny, fetch;
    k = n_user ? n_ku : n_ks;
    c = n_code;
    a = 0;
    if (k == 0) begin
      if (c <= 2) a = 7; else if (c == 3 || c == 6) a = 5;
    end else begin
      if (c == 2) a = 7; else if (c == 1 || c == 3) a = 5;
    end
    b = (n_nx || n_g) ? 6 : 7;
    m = 7;
    sh = 2 * (31 - int'(n_key));
    if (n_men) begin
      if (n_am[sh+1]) m = m & ~2;
      if (n_am[sh]) m = m & ~4;
      if (n_ien && n_im[sh]) m = m & ~1;
    end
    tot = a & b & m;
    fetch = (n_acc == 2'd2);
    need = fetch ? 1 : (n_acc == 2'd1) ? 2 : 4;
    deny = (tot & need) == 0;
    e_perm = tot[2:0];
    e_grant = !deny;
    e_cause = '0;
    if (deny && fetch) begin
      if ((b & 1) == 0) e_cause[5] = 1;
      else if ((a & 1) == 0) e_cause[4] = 1;
      if ((m & 1) == 0) e_cause[3] = 1;
    end
    if (deny && !fetch) begin
      e_cause[2] = (need & ~a) != 0;
      e_cause[1] = (need & ~m) != 0;
      e_cause[0] = (n_acc == 2'd1);
    end
  endtask

  task automatic compare();
    if (pend) begin
      chk(p_tag, "perm", {3'b0, perm}, {3'b0, e_perm});
      chk(p_tag, "grant", {5'b0, grant}, {5'b0, e_grant});
      chk(p_tag, "causes", {if_nxg, if_prot, if_key, df_prot, df_key, df_store}, e_cause);
    end
  endtask

  // compare previous vector, then apply staged one
  task automatic step(string tag);
    @(negedge clk);
    compare();
    acc_kind = n_acc; user_mode = n_user; seg_key_user = n_ku; seg_key_sup = n_ks;
    {pp_hi, pp_lo} = n_code; pte_noexec = n_nx; pte_guard = n_g; pte_key = n_key;
    amask = n_am; imask = n_im; key_mask_en = n_men; imask_en = n_ien;
    model();
    p_tag = tag;
    pend = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    // R11 reset clears outputs
    chk("R11", "reset", {perm, grant, if_nxg, if_prot}, 6'd0);
    chk("R11", "reset", {if_key, df_prot, df_key, df_store, 2'b0}, 6'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 key selection by privilege
    defaults(); n_user = 1; n_ku = 1; n_ks = 0; n_code = 3'd0; step("R1");
    defaults(); n_user = 0; n_ku = 1; n_ks = 0; n_code = 3'd0; step("R1");
    defaults(); n_user = 0; n_ku = 0; n_ks = 1; n_code = 3'd6; n_acc = 2'd2; step("R1");
    defaults(); n_user = 1; n_ku = 0; n_ks = 1; n_code = 3'd6; n_acc = 2'd2; step("R1");

    // R2 / R3 full code tables for every access kind
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 4; a++) begin
        defaults(); n_code = c[2:0]; n_acc = a[1:0]; step("R2");
        defaults(); n_code = c[2:0]; n_acc = a[1:0]; n_ks = 1; step("R3");
      end
    end

    // R4 no-execute and guarded
    defaults(); n_nx = 1; n_acc = 2'd2; step("R4");
    defaults(); n_g = 1; n_acc = 2'd0; step("R4");
    defaults(); n_g = 1; n_acc = 2'd1; step("R4");

    // R5 authority pair for key 3 is bits 57:56
    defaults(); n_key = 5'd3; n_am[57] = 1; n_acc = 2'd1; step("R5");
    defaults(); n_key = 5'd3; n_am[56] = 1; n_acc = 2'd0; step("R5");
    defaults(); n_key = 5'd3; n_am[56] = 1; n_acc = 2'd1; step("R5");
    defaults(); n_key = 5'd3; n_am[55] = 1; n_am[58] = 1; n_acc = 2'd1; step("R5");
    defaults(); n_key = 5'd31; n_am[1:0] = 2'b11; n_acc = 2'd0; step("R5");
    defaults(); n_key = 5'd0; n_am[63] = 1; n_acc = 2'd2; step("R5");

    // R6 instruction mask, low bit only, gated by its enable
    defaults(); n_key = 5'd3; n_im[56] = 1; n_acc = 2'd2; step("R6");
    defaults(); n_key = 5'd3; n_im[56] = 1; n_ien = 0; n_acc = 2'd2; step("R6");
    defaults(); n_key = 5'd3; n_im[57] = 1; n_acc = 2'd2; step("R6");
    defaults(); n_key = 5'd3; n_im[56] = 1; n_acc = 2'd0; step("R6");

    // R7 masks disabled
    defaults(); n_men = 0; n_am = '1; n_im = '1; n_acc = 2'd1; step("R7");
    defaults(); n_men = 0; n_am = '1; n_im = '1; n_acc = 2'd2; step("R7");

    // R8 combined AND, reserved kind acts as load
    defaults(); n_code = 3'd3; n_am[63] = 1; n_nx = 1; n_acc = 2'd3; step("R8");
    defaults(); n_code = 3'd3; n_am[62] = 1; n_acc = 2'd3; step("R8");

    // R9 fetch cause ordering
    defaults(); n_nx = 1; n_code = 3'd4; n_acc = 2'd2; step("R9");
    defaults(); n_code = 3'd4; n_im[62] = 1; n_acc = 2'd2; step("R9");
    defaults(); n_g = 1; n_code = 3'd4; n_im[62] = 1; n_acc = 2'd2; step("R9");

    // R10 data causes and store flag
    defaults(); n_code = 3'd3; n_am[63] = 1; n_acc = 2'd1; step("R10");
    defaults(); n_code = 3'd5; n_am[62] = 1; n_acc = 2'd0; step("R10");
    defaults(); n_ks = 1; n_code = 3'd0; n_acc = 2'd1; step("R10");

    // R11 / R8 random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      n_acc = r[1:0]; n_user = r[2]; n_ku = r[3]; n_ks = r[4];
      n_code = r[7:5]; n_nx = r[8] & r[9]; n_g = r[10] & r[11];
      n_key = r[16:12]; n_men = r[17] | r[18]; n_ien = r[19] | r[20];
      n_am = {$urandom, $urandom} & {$urandom, $urandom};
      n_im = {$urandom, $urandom} & {$urandom, $urandom};
      step("R11");
    end

    @(negedge clk);
    compare();
    pend = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule